// File: doc/BRIEF.md
# Oversampled Bit Synchroniser with Carrier Detect

This block takes the hard-limited output of a 1200 bit/s audio-tone demodulator and recovers both the bit timing and the data. It samples the line at programmable intervals, measured in base units of a fixed number of system clocks. On each bit-decision sample it lengthens or shortens the next interval according to where the most recent transitions fell. Each decided bit is NRZI-decoded and delivered with a one-clock valid strobe. Framing is left to the logic downstream.

Alongside the bit recovery, the block scores transitions by their position relative to earlier transitions. It keeps the scores from the current window and the two before it, and raises a carrier-detect flag when their sum is negative. A mode input picks one of two operating points. In three-sample mode the nominal interval is 4 units, and idle samples also lower the score. In two-sample mode the nominal interval is 6 units, and idle samples leave the score unchanged.

The sample phase is a three-state machine. State PH_DECIDE marks the bit-decision sample and always moves to PH_MID_A. From PH_MID_A the machine moves to PH_MID_B in three-sample mode and back to PH_DECIDE in two-sample mode. PH_MID_B always returns to PH_DECIDE. The state advances only on a sample, and reset puts it in PH_DECIDE.

Top module: `bitsync_dcd`

## Requirements
- R1: A synchronous reset clears the sample history, the previous levels, the accumulators, the window counter and the phase. While reset is held, bit_valid, bit_data and dcd read 0. The first sample falls on the CLK_PER_UNIT×nominal-th clock edge after reset is released.
- R2: Each sample interval lasts units×CLK_PER_UNIT clocks. The nominal value of units is 4 when mode_stat=1 (three-sample mode) and 6 when mode_stat=0 (two-sample mode). With a constant line, bit_valid pulses every 12×CLK_PER_UNIT clocks in both modes.
- R3: In three-sample mode, the interval after a decision sample is set from the low three history bits [2:0], newest in bit 0. A value of 3'b001 gives 5 units, a value of 3'b100 gives 3 units, and any other value gives 4 units.
- R4: In two-sample mode, the interval after a decision sample is set from the history bits [1:0]. A value of 2'b01 gives 7 units, a value of 2'b10 gives 5 units, and any other value gives 6 units.
- R5: The first sample after reset is a decision sample. After that, every third sample is a decision sample in three-sample mode and every second sample in two-sample mode. The samples in between always load the nominal interval. bit_valid is high for exactly the one clock that follows each decision sample.
- R6: The history register is 31 bits wide and shifts left by one on every sample. Bit 0 takes 1 when the sampled level differs from the level of the previous sample. The previous level is 0 after reset.
- R7: bit_data is 1 when the level at a decision sample equals the level at the previous decision sample, and 0 otherwise. The previous decision level is 0 after reset. bit_data holds its value between pulses.
- R8: On a sample whose new history bit 0 is 1, the accumulator changes by 16×P−N. P is history bit 1, plus 1 when history bits 30:1 are all zero. N is the sum of history bits 2, 3 and 4.
- R9: On a sample with no transition, the accumulator drops by 1 in three-sample mode and does not change in two-sample mode.
- R10: Every DCD_WINDOW samples, the window closes on that sample. At that point dcd takes the result of (accumulator including this sample + previous window + window before) < 0, and the accumulator reloads with 2. dcd changes only on the clock after a window closes, or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_stat | input | 1 | 1: three samples per bit, full idle penalty; 0: two samples per bit |
| line_in | input | 1 | Hard-limited demodulator output, assumed synchronous to clk |
| bit_valid | output | 1 | One-clock pulse with each recovered bit |
| bit_data | output | 1 | NRZI-decoded bit, valid with bit_valid |
| dcd | output | 1 | Carrier-detect flag |

## Verification
The assertions assume that mode_stat changes only while reset is held. Under that assumption the sample interval stays within its mode's range, the decision cadence has a fixed period, and dcd moves only after a window closes. They also assume that line_in is already synchronous to clk. The stimulus drives line_in and mode_stat on the falling edge, changes mode only inside a reset pulse, and uses only clean levels: steady silence, bit streams slightly off the nominal rate, alternating streams and per-clock noise.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    localparam int HIST_W = 31;

    typedef enum logic [1:0] {
        PH_DECIDE = 2'd0,
        PH_MID_A  = 2'd1,
        PH_MID_B  = 2'd2
    } phase_t;

    function automatic logic [2:0] nominal_units(input logic three_spb);
        return three_spb ? 3'd4 : 3'd6;
    endfunction

    function automatic logic [2:0] corrected_units(input logic three_spb, input logic [2:0] h);
        logic [2:0] u;
        if (three_spb) begin
            unique case (h)
                3'b001:  u = 3'd5;
                3'b100:  u = 3'd3;
                default: u = 3'd4;
            endcase
        end else begin
            unique case (h[1:0])
                2'b01:   u = 3'd7;
                2'b10:   u = 3'd5;
                default: u = 3'd6;
            endcase
        end
        return u;
    endfunction
endpackage

// File: rtl/bsd_timer.sv
module bsd_timer #(
    parameter int CLK_PER_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] nominal,
    input  logic [2:0] reload,
    output logic       sample_stb
);
    localparam int UCW = (CLK_PER_UNIT > 1) ? $clog2(CLK_PER_UNIT) : 1;
    localparam logic [UCW-1:0] UNIT_LAST = UCW'(CLK_PER_UNIT - 1);

    logic [UCW-1:0] unit_cnt;
    logic [2:0]     units_left;
    logic           tick;

    assign tick       = (unit_cnt == UNIT_LAST);
    assign sample_stb = tick && (units_left == 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            unit_cnt   <= '0;
            units_left <= nominal;
        end else begin
            unit_cnt <= tick ? '0 : unit_cnt + 1'b1;
            if (tick) begin
                units_left <= (units_left == 3'd1) ? reload : units_left - 3'd1;
            end
        end
    end
endmodule

// File: rtl/bsd_phase_fsm.sv
module bsd_phase_fsm
    import bsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_stat,
    input  logic              sample_stb,
    input  logic              line_in,
    output logic [HIST_W-1:0] hist_next,
    output logic [2:0]        next_units,
    output logic              bit_valid,
    output logic              bit_data
);
    phase_t            state, state_nxt;
    logic [HIST_W-1:0] hist;
    logic              last_lvl;
    logic              last_dec;
    logic              decide_now;

    assign hist_next  = {hist[HIST_W-2:0], line_in ^ last_lvl};
    assign decide_now = sample_stb && (state == PH_DECIDE);

    always_comb begin
        state_nxt = state;
        unique case (state)
            PH_DECIDE: state_nxt = PH_MID_A;
            PH_MID_A:  state_nxt = mode_stat ? PH_MID_B : PH_DECIDE;
            PH_MID_B:  state_nxt = PH_DECIDE;
            default:   state_nxt = PH_DECIDE;
        endcase
    end

    always_comb begin
        if (state == PH_DECIDE) next_units = corrected_units(mode_stat, hist_next[2:0]);
        else                    next_units = nominal_units(mode_stat);
    end

    // state register: phase, history and remembered levels
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_DECIDE;
            hist     <= '0;
            last_lvl <= 1'b0;
            last_dec <= 1'b0;
        end else if (sample_stb) begin
            state    <= state_nxt;
            hist     <= hist_next;
            last_lvl <= line_in;
            if (state == PH_DECIDE) last_dec <= line_in;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
        end else begin
            bit_valid <= decide_now;
            if (decide_now) bit_data <= ~(line_in ^ last_dec);
        end
    end
endmodule

// File: rtl/bsd_dcd.sv
module bsd_dcd
    import bsd_pkg::*;
#(
    parameter int DCD_WINDOW = 960
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_stat,
    input  logic              sample_stb,
    input  logic [HIST_W-1:0] hist_next,
    output logic              win_end,
    output logic              dcd
);
    localparam int WIN   = (DCD_WINDOW > 2) ? DCD_WINDOW : 2;
    localparam int WCW   = $clog2(WIN);
    localparam int ACC_W = $clog2(WIN * 32 + 8) + 2;
    localparam int SUM_W = ACC_W + 2;
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WIN - 1);

    logic [WCW-1:0]          win_cnt;
    logic signed [ACC_W-1:0] acc, s1, s2, acc_new;
    logic signed [SUM_W-1:0] sum3;
    logic [1:0]              pos, neg;
    logic signed [6:0]       delta;

    always_comb begin
        pos = {1'b0, hist_next[1]} + {1'b0, (hist_next[HIST_W-1:1] == '0)};
        neg = {1'b0, hist_next[2]} + {1'b0, hist_next[3]} + {1'b0, hist_next[4]};
        if (hist_next[0])  delta = $signed({1'b0, pos, 4'b0000}) - $signed({5'b00000, neg});
        else if (mode_stat) delta = -7'sd1;
        else               delta = 7'sd0;
        acc_new = acc + ACC_W'(delta);
        sum3    = SUM_W'(acc_new) + SUM_W'(s1) + SUM_W'(s2);
    end

    assign win_end = sample_stb && (win_cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
            acc     <= '0;
            s1      <= '0;
            s2      <= '0;
            dcd     <= 1'b0;
        end else if (sample_stb) begin
            if (win_end) begin
                win_cnt <= '0;
                dcd     <= (sum3 < 0);
                s2      <= s1;
                s1      <= acc_new;
                acc     <= ACC_W'(2);
            end else begin
                win_cnt <= win_cnt + 1'b1;
                acc     <= acc_new;
            end
        end
    end
endmodule

// File: rtl/bitsync_dcd.sv
module bitsync_dcd
    import bsd_pkg::*;
#(
    parameter int CLK_PER_UNIT = 8,
    parameter int DCD_WINDOW   = 960
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_stat,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_data,
    output logic dcd
);
    logic              sample_stb;
    logic [2:0]        next_units;
    logic [2:0]        nom_units;
    logic [HIST_W-1:0] hist_next;
    logic              win_end;

    assign nom_units = nominal_units(mode_stat);

    bsd_timer #(.CLK_PER_UNIT(CLK_PER_UNIT)) u_timer (
        .clk(clk), .rst(rst), .nominal(nom_units), .reload(next_units),
        .sample_stb(sample_stb)
    );

    bsd_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .mode_stat(mode_stat), .sample_stb(sample_stb),
        .line_in(line_in), .hist_next(hist_next), .next_units(next_units),
        .bit_valid(bit_valid), .bit_data(bit_data)
    );

    bsd_dcd #(.DCD_WINDOW(DCD_WINDOW)) u_dcd (
        .clk(clk), .rst(rst), .mode_stat(mode_stat), .sample_stb(sample_stb),
        .hist_next(hist_next), .win_end(win_end), .dcd(dcd)
    );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
    input logic       clk,
    input logic       rst,
    input logic       mode_stat,
    input logic       sample_stb,
    input logic [2:0] next_units,
    input logic       bit_valid,
    input logic       dcd,
    input logic       win_end
);
    // R3 R4: interval loaded at a sample stays within its mode's range
    a_r2_interval_range: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (mode_stat ? (next_units >= 3'd3 && next_units <= 3'd5)
                                  : (next_units >= 3'd5 && next_units <= 3'd7)));

    a_r5_valid_follows_sample: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(sample_stb));

    a_r5_valid_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    a_r10_dcd_moves_at_window: assert property (@(posedge clk) disable iff (rst)
        !$stable(dcd) |-> $past(win_end));
endmodule

bind bitsync_dcd bsd_checker u_chk (
    .clk(clk), .rst(rst), .mode_stat(mode_stat), .sample_stb(sample_stb),
    .next_units(next_units), .bit_valid(bit_valid), .dcd(dcd), .win_end(win_end)
);

// File: tb/sim_bitsync_dcd.sv
module sim_bitsync_dcd;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int WIN        = 48;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_stat = 1'b1;
    logic line_in = 1'b0;
    logic bit_valid, bit_data, dcd;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    bitsync_dcd #(.CLK_PER_UNIT(CPU), .DCD_WINDOW(WIN)) u0 (
        .clk(clk), .rst(rst), .mode_stat(mode_stat), .line_in(line_in),
        .bit_valid(bit_valid), .bit_data(bit_data), .dcd(dcd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int  m_edges, m_next_at, m_phase, m_wcnt, m_acc, m_s1, m_s2;
    bit  m_last, m_last_dec, m_valid, m_bit, m_dcd;
    bit  m_hist[$];

    function automatic int nom(bit three);
        return three ? 4 : 6;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_edges = 0; m_next_at = CPU * nom(mode_stat); m_phase = 0;
            m_wcnt = 0; m_acc = 0; m_s1 = 0; m_s2 = 0;
            m_last = 0; m_last_dec = 0; m_valid = 0; m_bit = 0; m_dcd = 0;
            m_hist.delete();
            for (int i = 0; i < 31; i++) m_hist.push_back(1'b0);
        end else begin
            m_edges++;
            m_valid = 0;
            if (m_edges == m_next_at) begin
                bit cur; int units; int p; int n; bit quiet;
                cur = line_in;
                m_hist.push_front(cur != m_last);
                void'(m_hist.pop_back());
                m_last = cur;
                units = nom(mode_stat);
                if (m_phase == 0) begin
                    m_valid = 1;
                    m_bit = (cur == m_last_dec);
                    m_last_dec = cur;
                    if (mode_stat) begin
                        if (!m_hist[2] && !m_hist[1] && m_hist[0]) units = 5;
                        else if (m_hist[2] && !m_hist[1] && !m_hist[0]) units = 3;
                    end else begin
                        if (!m_hist[1] && m_hist[0]) units = 7;
                        else if (m_hist[1] && !m_hist[0]) units = 5;
                    end
                end
                m_phase = (m_phase + 1) % (mode_stat ? 3 : 2);
                if (m_hist[0]) begin
                    quiet = 1;
                    for (int i = 1; i <= 30; i++) if (m_hist[i]) quiet = 0;
                    p = int'(m_hist[1]) + int'(quiet);
                    n = int'(m_hist[2]) + int'(m_hist[3]) + int'(m_hist[4]);
                    m_acc += 16 * p - n;
                end else if (mode_stat) begin
                    m_acc -= 1;
                end
                m_wcnt++;
                if (m_wcnt == WIN) begin
                    m_dcd = (m_acc + m_s1 + m_s2) < 0;
                    m_s2 = m_s1; m_s1 = m_acc; m_acc = 2; m_wcnt = 0;
                end
                m_next_at += CPU * units;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    bit compare_on = 1'b0;
    int dcd_high_seen = 0;
    always @(negedge clk) begin
        cyc++;
        if (compare_on && !rst) begin
            chk(bit_valid == m_valid, "R2 R3 R4 R5 R6 bit_valid", bit_valid, m_valid);
            chk(bit_data == m_bit, "R6 R7 bit_data", bit_data, m_bit);
            chk(dcd == m_dcd, "R8 R9 R10 dcd", dcd, m_dcd);
            if (dcd) dcd_high_seen++;
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog expired: actual %0d expected %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_reset(bit mode);
        @(negedge clk);
        rst = 1'b1; mode_stat = mode; line_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(bit_valid == 1'b0, "R1 reset bit_valid", bit_valid, 0);
        chk(bit_data == 1'b0, "R1 reset bit_data", bit_data, 0);
        chk(dcd == 1'b0, "R1 reset dcd", dcd, 0);
        rst = 1'b0;
    endtask

    task automatic first_sample(bit mode);
        int t = 0;
        while (!bit_valid && t < 100) begin @(negedge clk); t++; end
        // valid rises one clock after the sample edge CPU*nominal
        chk(t == CPU * nom(mode), "R1 first decision timing", t, CPU * nom(mode));
    endtask

    task automatic silence(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gap_check();
        int t = 0;
        while (!bit_valid) @(negedge clk);
        @(negedge clk);
        t = 1;
        while (!bit_valid && t < 200) begin @(negedge clk); t++; end
        chk(t == 12 * CPU, "R2 idle decision spacing", t, 12 * CPU);
    endtask

    task automatic data_stream(int per, int nbits, bit alternate);
        for (int b = 0; b < nbits; b++) begin
            if (alternate || ($urandom % 2 == 1)) line_in = ~line_in;
            repeat (per) @(negedge clk);
        end
    endtask

    task automatic noise(int n);
        for (int i = 0; i < n; i++) begin
            line_in = $urandom % 2;
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(7));
        for (int m = 1; m >= 0; m--) begin
            compare_on = 1'b0;
            do_reset(m[0]);
            compare_on = 1'b1;
            first_sample(m[0]);
            silence(300);
            gap_check();
            silence(WIN * 60);
            data_stream(25, 150, 1'b0);
            data_stream(23, 150, 1'b0);
            data_stream(24, 200, 1'b1);
            noise(WIN * 70);
            silence(200);
            gap_check();
            data_stream(26, 150, 1'b1);
            silence(WIN * 40);
        end
        chk(dcd_high_seen > 0, "R10 carrier flag raised at least once", dcd_high_seen, 1);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule